// File: doc/BRIEF.md
# Pin Event Detector

This block watches a port of 32 input pins and raises a sticky per-pin flag when a programmed condition is met. Every pin has its own control word. A 4-bit trigger code in that word selects the condition: an edge (rising, falling or both) that raises a DMA request, or an edge or a level that raises an interrupt. The same code decides which of the two port outputs the pin's flag feeds.

Software reaches the block through a simple synchronous register port. A write lands on the rising clock edge; read data is a combinational function of the address. Pin control words sit at a 4-byte stride from offset 0. A summary word at offset 0xA0 shows all 32 flags at once. Flags are cleared by writing 1, either to the flag bit of a pin's control word or to that pin's bit in the summary word. Pins pass through a two-stage synchronizer before detection.

Top module: `ped_event_top`

## Requirements
- R1: After reset every trigger code and flag is 0, both outputs are low, and every register reads 0.
- R2: The control word of pin n is at byte offset 4*n. It reads back the trigger code in bits 19:16 and the pin flag in bit 24, with all other bits 0. A write replaces the code with write-data bits 19:16.
- R3: Code 0, and every code that is not 1, 2, 3, 8, 9, 10, 11 or 12, never sets the pin's flag, whatever the pin does.
- R4: Codes 1 and 9 set the flag on a rising edge of the pin.
- R5: Codes 2 and 10 set the flag on a falling edge and ignore rising edges.
- R6: Codes 3 and 11 set the flag on either edge.
- R7: Code 8 sets the flag while the pin is low, and code 12 while it is high. After a clear, the flag reads 0 for one cycle and then sets again if the level is still present.
- R8: Writing a control word with bit 24 at 1 clears that pin's flag. Writing it with bit 24 at 0 leaves the flag unchanged.
- R9: The word at byte offset 0xA0 reads flag n in bit n. Writing 1 to bit n there clears flag n, and bits written 0 have no effect.
- R10: The interrupt output is high exactly while some flag with code 8 to 12 is set. The DMA request output is high exactly while some flag with code 1 to 3 is set. Both stay high until software clears the flags.
- R11: A pin change driven between clock edges shows in the flag after the third rising clock edge, and not after the second.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| pinIn | input | 32 | Asynchronous port pins |
| busAddr | input | ADDR_W (8) | Byte address of the register access |
| busWrEn | input | 1 | Write strobe, sampled on the rising edge |
| busWrData | input | 32 | Write data |
| busRdData | output | 32 | Read data for busAddr (combinational) |
| irqOut | output | 1 | Port interrupt, OR of flags with interrupt codes |
| dmaReq | output | 1 | Port DMA request, OR of flags with DMA codes |

## Verification
The bench checks the exact cycle in which a flag appears after a pin change. A synchronizer that is one stage short or one stage long would move that cycle. It drives edges against the codes that should ignore them, such as a rising edge under a falling-edge code and toggles under unlisted codes. A decoder that mapped codes loosely would set flags that should stay clear. A level flag is cleared while its level holds, to confirm it reads 0 for exactly one cycle and then returns. A design that let the level win over the clear would never show the 0. A design that cleared it for good would not show the 1 again. Writes with the flag bit at 0, and summary writes to other bits, confirm that a clear reaches only the flag it names.

// File: rtl/ped_pkg.sv
package ped_pkg;
  localparam int PIN_COUNT = 32;
  localparam int PIN_IDX_W = $clog2(PIN_COUNT);
  localparam int DATA_W    = 32;
  localparam int CODE_W    = 4;
  localparam int CODE_LSB  = 16;
  localparam int FLAG_BIT  = 24;
  localparam int SUM_OFFSET = 'hA0;

  localparam logic [CODE_W-1:0] TRIG_OFF      = 4'd0;
  localparam logic [CODE_W-1:0] TRIG_DMA_RISE = 4'd1;
  localparam logic [CODE_W-1:0] TRIG_DMA_FALL = 4'd2;
  localparam logic [CODE_W-1:0] TRIG_DMA_BOTH = 4'd3;
  localparam logic [CODE_W-1:0] TRIG_IRQ_LOW  = 4'd8;
  localparam logic [CODE_W-1:0] TRIG_IRQ_RISE = 4'd9;
  localparam logic [CODE_W-1:0] TRIG_IRQ_FALL = 4'd10;
  localparam logic [CODE_W-1:0] TRIG_IRQ_BOTH = 4'd11;
  localparam logic [CODE_W-1:0] TRIG_IRQ_HIGH = 4'd12;

  // Strobes from the register decoder to the datapath
  typedef struct packed {
    logic                  codeWr;
    logic [PIN_IDX_W-1:0]  codeSel;
    logic [CODE_W-1:0]     codeVal;
    logic [PIN_COUNT-1:0]  clrMask;
    logic                  rdPin;
    logic                  rdSum;
    logic [PIN_IDX_W-1:0]  rdSel;
  } strobe_t;

  function automatic logic codeIsDma(input logic [CODE_W-1:0] c);
    return (c == TRIG_DMA_RISE) || (c == TRIG_DMA_FALL) || (c == TRIG_DMA_BOTH);
  endfunction

  function automatic logic codeIsIrq(input logic [CODE_W-1:0] c);
    return (c >= TRIG_IRQ_LOW) && (c <= TRIG_IRQ_HIGH);
  endfunction
endpackage

// File: rtl/ped_bus_ctrl.sv
module ped_bus_ctrl
  import ped_pkg::*;
#(
  parameter int ADDR_W = 8
) (
  input  logic [ADDR_W-1:0] busAddr,
  input  logic              busWrEn,
  input  logic [DATA_W-1:0] busWrData,
  output strobe_t           strb
);
  localparam int PIN_SPAN_LSB = PIN_IDX_W + 2;

  logic                 aligned;
  logic                 inPinRange;
  logic                 isSum;
  logic [PIN_IDX_W-1:0] pinIdx;
  logic [PIN_COUNT-1:0] pinOneHot;

  always_comb begin
    aligned    = (busAddr[1:0] == 2'b00);
    inPinRange = aligned && (busAddr[ADDR_W-1:PIN_SPAN_LSB] == '0);
    isSum      = (busAddr == ADDR_W'(SUM_OFFSET));
    pinIdx     = busAddr[PIN_SPAN_LSB-1:2];
    pinOneHot  = '0;
    pinOneHot[pinIdx] = 1'b1;
  end

  always_comb begin
    strb         = '0;
    strb.codeSel = pinIdx;
    strb.rdSel   = pinIdx;
    strb.codeVal = busWrData[CODE_LSB +: CODE_W];
    strb.rdPin   = inPinRange;
    strb.rdSum   = isSum;
    strb.codeWr  = busWrEn && inPinRange;
    if (busWrEn && inPinRange && busWrData[FLAG_BIT])
      strb.clrMask = pinOneHot;
    else if (busWrEn && isSum)
      strb.clrMask = busWrData[PIN_COUNT-1:0];
  end
endmodule

// File: rtl/ped_pin_cell.sv
module ped_pin_cell
  import ped_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic              syncPin,
  input  logic              codeWr,
  input  logic [CODE_W-1:0] codeVal,
  input  logic              clr,
  output logic [CODE_W-1:0] code,
  output logic              flag,
  output logic              irqSel,
  output logic              dmaSel
);
  logic prevPin;
  logic rise, fall;
  logic edgeHit, levelHit;

  always_comb begin
    rise     = syncPin && !prevPin;
    fall     = !syncPin && prevPin;
    edgeHit  = 1'b0;
    levelHit = 1'b0;
    unique case (code)
      TRIG_DMA_RISE, TRIG_IRQ_RISE: edgeHit  = rise;
      TRIG_DMA_FALL, TRIG_IRQ_FALL: edgeHit  = fall;
      TRIG_DMA_BOTH, TRIG_IRQ_BOTH: edgeHit  = rise || fall;
      TRIG_IRQ_LOW:                 levelHit = !syncPin;
      TRIG_IRQ_HIGH:                levelHit = syncPin;
      default: ;
    endcase
    irqSel = codeIsIrq(code);
    dmaSel = codeIsDma(code);
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      prevPin <= 1'b0;
      code    <= TRIG_OFF;
      flag    <= 1'b0;
    end else begin
      prevPin <= syncPin;
      if (codeWr) code <= codeVal;
      // a fresh edge survives a coincident clear; a level yields to it
      flag <= edgeHit || ((levelHit || flag) && !clr);
    end
  end
endmodule

// File: rtl/ped_datapath.sv
module ped_datapath
  import ped_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic [PIN_COUNT-1:0] pinIn,
  input  strobe_t              strb,
  output logic [DATA_W-1:0]    rdData,
  output logic [PIN_COUNT-1:0] flagVec,
  output logic [PIN_COUNT-1:0] irqSelVec,
  output logic [PIN_COUNT-1:0] dmaSelVec
);
  logic [PIN_COUNT-1:0] syncStg [SYNC_STAGES];
  logic [CODE_W-1:0]    codeArr [PIN_COUNT];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      for (int s = 0; s < SYNC_STAGES; s++) syncStg[s] <= '0;
    end else begin
      syncStg[0] <= pinIn;
      for (int s = 1; s < SYNC_STAGES; s++) syncStg[s] <= syncStg[s-1];
    end
  end

  for (genvar i = 0; i < PIN_COUNT; i++) begin : g_pin
    ped_pin_cell u_cell (
      .clk     (clk),
      .rstN    (rstN),
      .syncPin (syncStg[SYNC_STAGES-1][i]),
      .codeWr  (strb.codeWr && (strb.codeSel == PIN_IDX_W'(i))),
      .codeVal (strb.codeVal),
      .clr     (strb.clrMask[i]),
      .code    (codeArr[i]),
      .flag    (flagVec[i]),
      .irqSel  (irqSelVec[i]),
      .dmaSel  (dmaSelVec[i])
    );
  end

  always_comb begin
    rdData = '0;
    if (strb.rdPin) begin
      rdData[FLAG_BIT]            = flagVec[strb.rdSel];
      rdData[CODE_LSB +: CODE_W]  = codeArr[strb.rdSel];
    end else if (strb.rdSum) begin
      rdData[PIN_COUNT-1:0] = flagVec;
    end
  end
endmodule

// File: rtl/ped_event_top.sv
module ped_event_top
  import ped_pkg::*;
#(
  parameter int ADDR_W      = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic [PIN_COUNT-1:0] pinIn,
  input  logic [ADDR_W-1:0]    busAddr,
  input  logic                 busWrEn,
  input  logic [DATA_W-1:0]    busWrData,
  output logic [DATA_W-1:0]    busRdData,
  output logic                 irqOut,
  output logic                 dmaReq
);
  strobe_t              ctrlStrobes;
  logic [PIN_COUNT-1:0] flagVec;
  logic [PIN_COUNT-1:0] irqSelVec;
  logic [PIN_COUNT-1:0] dmaSelVec;

  ped_bus_ctrl #(.ADDR_W(ADDR_W)) u_ctrl (
    .busAddr   (busAddr),
    .busWrEn   (busWrEn),
    .busWrData (busWrData),
    .strb      (ctrlStrobes)
  );

  ped_datapath #(.SYNC_STAGES(SYNC_STAGES)) u_dp (
    .clk       (clk),
    .rstN      (rstN),
    .pinIn     (pinIn),
    .strb      (ctrlStrobes),
    .rdData    (busRdData),
    .flagVec   (flagVec),
    .irqSelVec (irqSelVec),
    .dmaSelVec (dmaSelVec)
  );

  assign irqOut = |(flagVec & irqSelVec);
  assign dmaReq = |(flagVec & dmaSelVec);
endmodule

// File: rtl/ped_event_chk.sv
module ped_event_chk
  import ped_pkg::*;
(
  input logic                 clk,
  input logic                 rstN,
  input logic                 busWrEn,
  input logic                 irqOut,
  input logic                 dmaReq,
  input logic [PIN_COUNT-1:0] flagVec,
  input logic [PIN_COUNT-1:0] irqSelVec,
  input logic [PIN_COUNT-1:0] dmaSelVec,
  input logic [PIN_COUNT-1:0] clrMask
);
  for (genvar i = 0; i < PIN_COUNT; i++) begin : g_chk
    // R8 / R9: a flag only drops in the cycle after a clear strobe for it
    a_r8_fall_needs_clear: assert property (@(posedge clk) disable iff (!rstN)
      $fell(flagVec[i]) |-> $past(clrMask[i]));
    // R3: a disabled pin with a clear flag keeps it clear
    a_r3_off_stays_clear: assert property (@(posedge clk) disable iff (!rstN)
      (!irqSelVec[i] && !dmaSelVec[i] && !flagVec[i]) |=> !flagVec[i]);
  end

  // R10: outputs only drop after a register write
  a_r10_irq_sticky: assert property (@(posedge clk) disable iff (!rstN)
    $fell(irqOut) |-> $past(busWrEn));
  a_r10_dma_sticky: assert property (@(posedge clk) disable iff (!rstN)
    $fell(dmaReq) |-> $past(busWrEn));
  // R10: an output can only rise while some flag is set
  a_r10_out_has_flag: assert property (@(posedge clk) disable iff (!rstN)
    (irqOut || dmaReq) |-> (flagVec != '0));
endmodule

bind ped_event_top ped_event_chk u_chk (
  .clk       (clk),
  .rstN      (rstN),
  .busWrEn   (busWrEn),
  .irqOut    (irqOut),
  .dmaReq    (dmaReq),
  .flagVec   (flagVec),
  .irqSelVec (irqSelVec),
  .dmaSelVec (dmaSelVec),
  .clrMask   (ctrlStrobes.clrMask)
);

// File: tb/ped_event_top_tb.sv
module ped_event_top_tb;
  localparam int CLK_PERIOD = 10;
  localparam int ADDR_W = 8;
  localparam logic [7:0] SUM = 8'hA0;

  logic        clk = 1'b0;
  logic        rstN;
  logic [31:0] pinIn;
  logic [7:0]  busAddr;
  logic        busWrEn;
  logic [31:0] busWrData;
  logic [31:0] busRdData;
  logic        irqOut;
  logic        dmaReq;

  int checks = 0;
  int errors = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  ped_event_top #(.ADDR_W(ADDR_W)) u_dut (
    .clk(clk), .rstN(rstN), .pinIn(pinIn), .busAddr(busAddr),
    .busWrEn(busWrEn), .busWrData(busWrData), .busRdData(busRdData),
    .irqOut(irqOut), .dmaReq(dmaReq)
  );

  task automatic check(input string tag, input logic [31:0] got, input logic [31:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, got, exp);
    end
  endtask

  task automatic waitNeg(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic busWrite(input logic [7:0] a, input logic [31:0] d);
    busAddr = a; busWrData = d; busWrEn = 1'b1;
    @(negedge clk);
    busWrEn = 1'b0; busWrData = '0;
  endtask

  task automatic busRead(input logic [7:0] a, output logic [31:0] d);
    busAddr = a;
    #1 d = busRdData;
  endtask

  task automatic checkFlag(input string tag, input int pin, input logic exp);
    logic [31:0] d;
    busRead(SUM, d);
    check(tag, {31'b0, d[pin]}, {31'b0, exp});
  endtask

  task automatic finishRun();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  endtask

  task automatic testReset();
    logic [31:0] d;
    check("R1 irqOut after reset", {31'b0, irqOut}, 32'd0);
    check("R1 dmaReq after reset", {31'b0, dmaReq}, 32'd0);
    busRead(8'h00, d); check("R1 pin0 word", d, 32'd0);
    busRead(8'h7C, d); check("R1 pin31 word", d, 32'd0);
    busRead(SUM, d);   check("R1 summary", d, 32'd0);
  endtask

  task automatic testCodesOff();
    logic [31:0] d;
    busWrite(8'h14, 32'hFFFF_FFFF);
    busRead(8'h14, d); check("R2 pin5 readback code 15", d, 32'h000F_0000);
    busWrite(8'h1C, 32'h0005_0000);
    busRead(8'h1C, d); check("R2 pin7 readback code 5", d, 32'h0005_0000);
    pinIn[5] = 1; pinIn[6] = 1; pinIn[7] = 1; waitNeg(4);
    pinIn[5] = 0; pinIn[6] = 0; pinIn[7] = 0; waitNeg(4);
    busRead(SUM, d); check("R3 unlisted and zero codes stay clear", d, 32'd0);
    check("R3 no irq", {31'b0, irqOut}, 32'd0);
    check("R3 no dma", {31'b0, dmaReq}, 32'd0);
  endtask

  task automatic testRise();
    logic [31:0] d;
    busWrite(8'h04, 32'h0001_0000);
    pinIn[1] = 1; waitNeg(2);
    checkFlag("R11 flag not yet after two edges", 1, 1'b0);
    waitNeg(1);
    checkFlag("R4 code 1 rising edge flag", 1, 1'b1);
    check("R10 dma from code 1", {31'b0, dmaReq}, 32'd1);
    check("R10 no irq from code 1", {31'b0, irqOut}, 32'd0);
    busRead(8'h04, d); check("R2 flag bit 24 in pin word", d, 32'h0101_0000);
    pinIn[1] = 0; waitNeg(4);
    check("R10 dma sticky after pin falls", {31'b0, dmaReq}, 32'd1);
    busWrite(8'h04, 32'h0001_0000);
    checkFlag("R8 write with bit24 at 0 keeps flag", 1, 1'b1);
    busWrite(8'h04, 32'h0101_0000);
    checkFlag("R8 write with bit24 at 1 clears flag", 1, 1'b0);
    check("R10 dma low after clear", {31'b0, dmaReq}, 32'd0);
    busWrite(8'h34, 32'h0009_0000);
    pinIn[13] = 1; waitNeg(3);
    checkFlag("R4 code 9 rising edge flag", 13, 1'b1);
    check("R10 irq from code 9", {31'b0, irqOut}, 32'd1);
    busWrite(SUM, 32'h0000_2000);
    check("R9 irq low after summary clear", {31'b0, irqOut}, 32'd0);
  endtask

  task automatic testFall();
    logic [31:0] d;
    busWrite(8'h08, 32'h000A_0000);
    pinIn[2] = 1; waitNeg(4);
    checkFlag("R5 code 10 ignores rising edge", 2, 1'b0);
    pinIn[2] = 0; waitNeg(3);
    checkFlag("R5 code 10 falling edge flag", 2, 1'b1);
    busRead(SUM, d); check("R9 summary shows bit 2", d, 32'h0000_0004);
    busWrite(SUM, 32'h0000_0001);
    checkFlag("R9 summary write of other bit keeps flag", 2, 1'b1);
    busWrite(SUM, 32'h0000_0004);
    checkFlag("R9 summary write 1 clears flag", 2, 1'b0);
    busWrite(8'h38, 32'h0002_0000);
    pinIn[14] = 1; waitNeg(4);
    checkFlag("R5 code 2 ignores rising edge", 14, 1'b0);
    pinIn[14] = 0; waitNeg(3);
    check("R5 code 2 falling edge raises dma", {31'b0, dmaReq}, 32'd1);
    busWrite(SUM, 32'h0000_4000);
  endtask

  task automatic testEither();
    busWrite(8'h0C, 32'h000B_0000);
    pinIn[3] = 1; waitNeg(3);
    checkFlag("R6 code 11 rising edge", 3, 1'b1);
    busWrite(SUM, 32'h0000_0008);
    pinIn[3] = 0; waitNeg(3);
    checkFlag("R6 code 11 falling edge", 3, 1'b1);
    busWrite(SUM, 32'h0000_0008);
    busWrite(8'h10, 32'h0003_0000);
    pinIn[4] = 1; waitNeg(3);
    check("R6 code 3 rising edge dma", {31'b0, dmaReq}, 32'd1);
    busWrite(SUM, 32'h0000_0010);
    pinIn[4] = 0; waitNeg(3);
    check("R6 code 3 falling edge dma", {31'b0, dmaReq}, 32'd1);
    busWrite(SUM, 32'h0000_0010);
  endtask

  task automatic testLevel();
    busWrite(8'h20, 32'h000C_0000);
    pinIn[8] = 1; waitNeg(3);
    checkFlag("R7 code 12 high level", 8, 1'b1);
    check("R10 irq from level", {31'b0, irqOut}, 32'd1);
    busWrite(8'h20, 32'h010C_0000);
    checkFlag("R7 flag reads 0 right after clear", 8, 1'b0);
    waitNeg(1);
    checkFlag("R7 flag returns while level holds", 8, 1'b1);
    pinIn[8] = 0; waitNeg(3);
    busWrite(SUM, 32'h0000_0100);
    waitNeg(3);
    checkFlag("R7 stays clear once level gone", 8, 1'b0);
    busWrite(8'h24, 32'h0008_0000);
    checkFlag("R7 code 8 not yet on write edge", 9, 1'b0);
    waitNeg(1);
    checkFlag("R7 code 8 low level", 9, 1'b1);
    busWrite(8'h24, 32'h0100_0000);
    waitNeg(2);
    checkFlag("R3 code 0 after clear stays clear", 9, 1'b0);
    check("R10 irq low at end", {31'b0, irqOut}, 32'd0);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog actual=%h expected=%h", 32'd0, 32'd1);
    finishRun();
  end

  initial begin
    rstN = 0; pinIn = '0; busAddr = '0; busWrEn = 0; busWrData = '0;
    waitNeg(3);
    rstN = 1;
    waitNeg(1);
    testReset();
    testCodesOff();
    testRise();
    testFall();
    testEither();
    testLevel();
    finishRun();
  end
endmodule